// File: doc/BRIEF.md
# Power-Down Mode and Wake Controller

This block decides when the processor clock may tick and when the main oscillator may run. In the running state it issues a one-cycle processor clock enable every 4, 8 or 64 oscillator cycles, picked by a divider select input. A one-cycle request strobe moves it into one of two low-power states. The light state keeps the oscillator running for the peripherals and only withholds the processor enable. The deep state also turns the oscillator off.

Wake-up comes from a vector of interrupt requests, each qualified by its own enable bit. From the light state an enabled request resumes execution at once. From the deep state the oscillator is switched back on and the processor enable stays blocked for a stabilization interval. That interval is picked by a software select when the wake came from an interrupt. When the block leaves reset it applies a fixed long hold of 2^RESET_WAIT_LOG2 cycles. The wake logic is clocked by a reference that keeps running while the oscillator enable is low. Oscillator analog behaviour lies outside the block.

Top module: `power_wake_ctrl`

## Requirements
- R1: While reset is asserted the state code is 3 (settling), the processor enable is low and the oscillator enable is high. After reset is released the block stays in settling for exactly 2^RESET_WAIT_LOG2 clock edges, then enters running (code 0).
- R2: In running, a deep-sleep strobe moves the block to the deep state (code 2) on the next edge and drops the oscillator enable. If the light-sleep strobe is also high in that cycle, the deep state is still chosen.
- R3: In running, a light-sleep strobe without a deep-sleep strobe moves the block to the light state (code 1) on the next edge. There the oscillator enable stays high and the processor enable stays low.
- R4: In the light state, any wake request whose enable bit is set returns the block to running on the next edge, with no settling interval.
- R5: A wake request whose enable bit is clear has no effect in the light or the deep state.
- R6: In the deep state, an enabled wake request moves the block to settling (code 3) with the oscillator enabled. It returns to running 2^(INT_LOG2_MIN + interval select) edges later, which is that count plus one edge after the request was sampled.
- R7: The processor enable is high only in running and is a one-cycle pulse once per divided period. The period is 4 cycles for divider select 0, 8 for select 1, and 64 for selects 2 and 3.
- R8: A change of the divider select takes effect only after the current divided period has finished. The period in progress keeps its old length.
- R9: After the block enters running, the first processor enable pulse comes one full divided period later, that is, period minus one edges after the state first shows running.
- R10: Sleep strobes outside the running state are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on reference clock, one oscillator period per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | Light-sleep request strobe |
| stopReq | input | 1 | Deep-sleep request strobe |
| wakeReq | input | WAKE_N | Interrupt wake requests |
| wakeEn | input | WAKE_N | Per-request wake enable bits |
| intWaitSel | input | 2 | Settling interval select for interrupt wake |
| divSel | input | 2 | Processor clock divider select |
| cpuClkEn | output | 1 | One-cycle processor clock enable |
| oscEn | output | 1 | Main oscillator enable |
| pmState | output | 2 | State code: 0 running, 1 light, 2 deep, 3 settling |

## Verification
Two pairs of events can land in the same cycle. The first pair is the two sleep strobes. The bench raises both in one running cycle and expects the deep state with the oscillator off, never the light state. The second pair is a divider select change and the end of a divided period. The bench changes the select one cycle after a pulse and measures the two following pulse gaps. The first gap must keep the old length and the second must take the new one, so the period never gets cut short.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2,
    PM_WAIT = 2'd3
  } pmState_t;

  typedef struct packed {
    logic loadIntWait;
    logic countWait;
    logic runDiv;
  } pmStrobe_t;
endpackage

// File: rtl/pwr_ctrl_fsm.sv
module pwr_ctrl_fsm
  import pwr_pkg::*;
#(
  parameter int WAKE_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idleReq,
  input  logic              stopReq,
  input  logic [WAKE_N-1:0] wakeReq,
  input  logic [WAKE_N-1:0] wakeEn,
  input  logic              waitDone,
  output pmStrobe_t         strobe,
  output logic              oscEn,
  output pmState_t          state
);
  pmState_t nextState;
  logic     wakeHit;

  assign wakeHit = |(wakeReq & wakeEn);

  always_comb begin
    nextState = state;
    unique case (state)
      PM_RUN: begin
        if (stopReq)      nextState = PM_STOP;
        else if (idleReq) nextState = PM_IDLE;
      end
      PM_IDLE: if (wakeHit)  nextState = PM_RUN;
      PM_STOP: if (wakeHit)  nextState = PM_WAIT;
      PM_WAIT: if (waitDone) nextState = PM_RUN;
      default: nextState = PM_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_WAIT;
    else       state <= nextState;
  end

  always_comb begin
    strobe.loadIntWait = (state == PM_STOP) && wakeHit;
    strobe.countWait   = (state == PM_WAIT);
    strobe.runDiv      = (state == PM_RUN);
  end

  assign oscEn = (state != PM_STOP);
endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int RESET_WAIT_LOG2 = 17,
  parameter int INT_LOG2_MIN    = 9,
  parameter int DIV_FAST_LOG2   = 2,
  parameter int DIV_MID_LOG2    = 3,
  parameter int DIV_SLOW_LOG2   = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  pmStrobe_t  strobe,
  input  logic [1:0] intWaitSel,
  input  logic [1:0] divSel,
  output logic       waitDone,
  output logic       cpuClkEn
);
  localparam int CW    = RESET_WAIT_LOG2;
  localparam int DIV_W = DIV_SLOW_LOG2;

  logic [CW-1:0]    waitCnt;
  logic [CW-1:0]    intLoad;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic [1:0]       activeSel;

  function automatic logic [DIV_W-1:0] lastOf(input logic [1:0] sel);
    case (sel)
      2'd0:    lastOf = DIV_W'((1 << DIV_FAST_LOG2) - 1);
      2'd1:    lastOf = DIV_W'((1 << DIV_MID_LOG2) - 1);
      default: lastOf = DIV_W'((1 << DIV_SLOW_LOG2) - 1);
    endcase
  endfunction

  // Stabilization counter: reset value is the long hold, interrupt wake loads a short one.
  assign intLoad  = CW'((1 << (INT_LOG2_MIN + 32'(intWaitSel))) - 1);
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           waitCnt <= '1;
    else if (strobe.loadIntWait)         waitCnt <= intLoad;
    else if (strobe.countWait && !waitDone) waitCnt <= waitCnt - 1'b1;
  end

  // Divider: the period length is latched only at a period boundary.
  assign divLast  = lastOf(activeSel);
  assign cpuClkEn = strobe.runDiv && (divCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      activeSel <= 2'd0;
    end else if (!strobe.runDiv) begin
      divCnt    <= '0;
      activeSel <= divSel;
    end else if (divCnt == divLast) begin
      divCnt    <= '0;
      activeSel <= divSel;
    end else begin
      divCnt    <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/power_wake_ctrl.sv
module power_wake_ctrl
  import pwr_pkg::*;
#(
  parameter int WAKE_N          = 4,
  parameter int RESET_WAIT_LOG2 = 17,
  parameter int INT_LOG2_MIN    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idleReq,
  input  logic              stopReq,
  input  logic [WAKE_N-1:0] wakeReq,
  input  logic [WAKE_N-1:0] wakeEn,
  input  logic [1:0]        intWaitSel,
  input  logic [1:0]        divSel,
  output logic              cpuClkEn,
  output logic              oscEn,
  output logic [1:0]        pmState
);
  pmStrobe_t strobe;
  pmState_t  state;
  logic      waitDone;

  pwr_ctrl_fsm #(.WAKE_N(WAKE_N)) ctrl (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .stopReq(stopReq),
    .wakeReq(wakeReq), .wakeEn(wakeEn), .waitDone(waitDone),
    .strobe(strobe), .oscEn(oscEn), .state(state)
  );

  pwr_datapath #(
    .RESET_WAIT_LOG2(RESET_WAIT_LOG2), .INT_LOG2_MIN(INT_LOG2_MIN)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intWaitSel(intWaitSel),
    .divSel(divSel), .waitDone(waitDone), .cpuClkEn(cpuClkEn)
  );

  assign pmState = state;
endmodule

// File: rtl/power_wake_ctrl_checker.sv
module power_wake_ctrl_checker #(
  parameter int WAKE_N = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              idleReq,
  input logic              stopReq,
  input logic [WAKE_N-1:0] wakeReq,
  input logic [WAKE_N-1:0] wakeEn,
  input logic              cpuClkEn,
  input logic              oscEn,
  input logic [1:0]        pmState
);
  assert_enable_only_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> pmState == 2'd0);

  assert_enable_is_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |=> !cpuClkEn);

  assert_osc_off_only_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> pmState == 2'd2);

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 2'd0 && stopReq) |=> pmState == 2'd2);

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 2'd1 && |(wakeReq & wakeEn)) |=> pmState == 2'd0);

  assert_masked_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pmState == 2'd1 && !(|(wakeReq & wakeEn))) |=> pmState == 2'd1);

  assert_stop_needs_settle_R6: assert property (@(posedge clk) disable iff (!rstN)
    pmState == 2'd2 |=> pmState != 2'd0);
endmodule

bind power_wake_ctrl power_wake_ctrl_checker #(.WAKE_N(WAKE_N)) chk (
  .clk(clk), .rstN(rstN), .idleReq(idleReq), .stopReq(stopReq),
  .wakeReq(wakeReq), .wakeEn(wakeEn), .cpuClkEn(cpuClkEn),
  .oscEn(oscEn), .pmState(pmState)
);

// File: tb/power_wake_ctrl_test.sv
module power_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE_N     = 4;
  localparam int RST_LOG2   = 8;
  localparam int INT_MIN    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              idleReq = 1'b0;
  logic              stopReq = 1'b0;
  logic [WAKE_N-1:0] wakeReq = '0;
  logic [WAKE_N-1:0] wakeEn = '0;
  logic [1:0]        intWaitSel = 2'd0;
  logic [1:0]        divSel = 2'd0;
  logic              cpuClkEn;
  logic              oscEn;
  logic [1:0]        pmState;

  int checks = 0;
  int fails  = 0;

  power_wake_ctrl #(.WAKE_N(WAKE_N), .RESET_WAIT_LOG2(RST_LOG2), .INT_LOG2_MIN(INT_MIN)) uut (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .stopReq(stopReq),
    .wakeReq(wakeReq), .wakeEn(wakeEn), .intWaitSel(intWaitSel),
    .divSel(divSel), .cpuClkEn(cpuClkEn), .oscEn(oscEn), .pmState(pmState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edgesToRun(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pmState != 2'd0 && n < 2000);
  endtask

  task automatic edgesToPulse(input int chg, input logic [1:0] newSel, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (chg != 0 && n == 1) divSel = newSel;
    end while (!cpuClkEn && n < 500);
  endtask

  task automatic testReset;
    int n;
    rstN = 1'b0;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    check("R1 reset state", pmState, 3);
    check("R1 reset cpu enable", cpuClkEn, 0);
    check("R1 reset osc enable", oscEn, 1);
    rstN = 1'b1;
    edgesToRun(n);
    check("R1 settle length", n, 1 << RST_LOG2);
    edgesToPulse(0, 2'd0, n);
    check("R9 first pulse", n, 3);
    edgesToPulse(0, 2'd0, n);
    check("R7 period sel0", n, 4);
  endtask

  task automatic testDivider(input logic [1:0] newSel, input int oldP, input int newP);
    int g1, g2;
    edgesToPulse(1, newSel, g1);
    check("R8 old period kept", g1, oldP);
    edgesToPulse(0, newSel, g2);
    check("R7 new period", g2, newP);
  endtask

  task automatic testIdle;
    int n;
    @(negedge clk); idleReq = 1'b1;
    @(negedge clk); idleReq = 1'b0;
    check("R3 idle state", pmState, 1);
    check("R3 idle osc", oscEn, 1);
    n = 0;
    wakeReq = 4'b0010; wakeEn = 4'b1101;
    repeat (4) begin
      @(negedge clk);
      n += cpuClkEn;
    end
    check("R3 no cpu enable in idle", n, 0);
    check("R5 masked wake idle", pmState, 1);
    stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    @(negedge clk);
    check("R10 strobe ignored state", pmState, 1);
    check("R10 strobe ignored osc", oscEn, 1);
    wakeEn = 4'b0010;
    @(negedge clk);
    check("R4 idle wake", pmState, 0);
    wakeReq = '0; wakeEn = '0;
  endtask

  task automatic enterStop(input logic both);
    @(negedge clk); stopReq = 1'b1; idleReq = both;
    @(negedge clk); stopReq = 1'b0; idleReq = 1'b0;
    check("R2 stop state", pmState, 2);
    check("R2 stop osc", oscEn, 0);
  endtask

  task automatic testStop(input logic [1:0] sel, input logic both);
    int n;
    enterStop(both);
    intWaitSel = sel;
    wakeReq = 4'b1000; wakeEn = 4'b0111;
    repeat (3) @(negedge clk);
    check("R5 masked wake stop", pmState, 2);
    wakeEn = 4'b1000;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check("R6 settle state", pmState, 3);
        check("R6 settle osc", oscEn, 1);
        wakeReq = '0; wakeEn = '0;
      end
    end while (pmState != 2'd0 && n < 2000);
    check("R6 settle length", n, (1 << (INT_MIN + sel)) + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testDivider(2'd1, 4, 8);
    testDivider(2'd2, 8, 64);
    testDivider(2'd3, 64, 64);
    testDivider(2'd0, 64, 4);
    testIdle();
    testStop(2'd0, 1'b0);
    testStop(2'd3, 1'b0);
    testStop(2'd1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule